// File: doc/BRIEF.md
# Programmable CRC Engine

This block computes a cyclic redundancy check over data that software writes to it through a small register port. Three generator polynomials are available, two 16-bit and one 32-bit. Four independent flags control the checksum. One flag mirrors the bits of the incoming data and one inverts them. The other two mirror and invert the checksum as it is read out. Software first programs the mode. Writing a starting value then begins a computation. Each data write advances the checksum by one byte or by four bytes in a single clock cycle.

The running state is held untransformed. Reading the checksum with both output flags clear gives that raw state. Software can store it and later write it back as the starting value to continue an interrupted computation. The output flags only change how the checksum is presented, so they can be toggled at any time.

The request port has no back-pressure. A request presented with `req_valid` high is taken on that clock edge, and a write can be issued every cycle. Reads need no handshake: `rd_data` is a combinational function of `req_addr` and the current registers.

Top module: `crc_engine`

## Requirements
- R1: After reset the mode register reads 0 and the checksum at address 0x8 reads 0x0000FFFF.
- R2: The mode register at address 0x0 holds six bits, all of which read back; bits above them read as zero. Bits [1:0] select the polynomial: 0 gives 0x1021, 1 gives 0x8005, 2 gives 0x04C11DB7 (32-bit), and 3 behaves as 0x1021. Bit 2 mirrors input bytes, bit 3 inverts input data, bit 4 mirrors the checksum on read, and bit 5 inverts it on read.
- R3: A write to address 0x4 loads the running state on that clock edge. With a 16-bit polynomial selected, only the low 16 bits are kept.
- R4: A write to address 0x8 with `req_size`=0 advances the state over `req_wdata[7:0]` in one cycle, most significant bit first. The update shifts the state left and XORs in the polynomial whenever the top state bit (bit 15 or bit 31, by width) XOR the data bit is 1.
- R5: A write to address 0x8 with `req_size`=1 advances the state over four bytes in one cycle, byte [7:0] first and byte [31:24] last. The result equals four byte writes of those bytes in that order.
- R6: The input flags act on each byte before it enters the update. Mirroring reverses the bit order within the byte, and inversion complements the byte.
- R7: The checksum read at 0x8 is the state taken over the polynomial width (16 or 32 bits). It is mirrored across that width if bit 4 is set, then inverted across that width if bit 5 is set, then zero-extended to 32 bits. Writing the mode register never changes the state.
- R8: With bits 4 and 5 clear, the checksum read is the raw state. Writing that value to 0x4 and continuing gives the same result as an uninterrupted run.
- R9: With mode 0 and seed 0xFFFF, the ASCII bytes "123456789" give 0x29B1.
- R10: With mode 0x36 and seed 0xFFFFFFFF, the same bytes give 0xCBF43926.
- R11: Nothing changes when `req_valid` is low, when the request is a read, or when a write goes to any address other than 0x0, 0x4 or 0x8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | Data write width: 0 = byte, 1 = 32-bit word |
| req_addr | input | 4 | Register address (0x0 mode, 0x4 seed, 0x8 data/checksum) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `req_addr` |

## Verification
A wrong state bit is held in the state register and feeds every later update. The checksum read at 0x8 therefore differs from the model on the cycle right after the faulty write, and it stays wrong until the next seed load. The bench reads the checksum after every random operation, so a bad lane order, a wrong reflection width or a disturbed state shows up within one operation. The known check values and the split-and-resume run pin down the absolute polynomial and bit-order conventions. A model that only agreed with itself could not do that.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int LANES  = DATA_W / 8;
  localparam int NARROW = 16;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SEED = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 4'h8;

  localparam logic [DATA_W-1:0] RESET_STATE = 32'h0000_FFFF;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_ANSI  = 2'd1,
    POLY_WIDE  = 2'd2,
    POLY_RSVD  = 2'd3
  } poly_sel_e;

  typedef struct packed {
    logic      inv_out;
    logic      mir_out;
    logic      inv_in;
    logic      mir_in;
    poly_sel_e poly;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [DATA_W-1:0] poly_taps(input poly_sel_e sel);
    case (sel)
      POLY_ANSI: poly_taps = 32'h0000_8005;
      POLY_WIDE: poly_taps = 32'h04C1_1DB7;
      default:   poly_taps = 32'h0000_1021;
    endcase
  endfunction

  function automatic logic poly_is_wide(input poly_sel_e sel);
    poly_is_wide = (sel == POLY_WIDE);
  endfunction
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int W     = 32,
  parameter int NW    = 16,
  parameter int BITS  = 8
) (
  input  logic [W-1:0]    state_i,
  input  logic [BITS-1:0] byte_i,
  input  logic            wide_i,
  input  logic [W-1:0]    poly_i,
  output logic [W-1:0]    state_o
);
  logic [BITS:0][W-1:0] chain;
  assign chain[0] = state_i;

  generate
    for (genvar b = 0; b < BITS; b++) begin : g_bit
      logic         fb;
      logic [W-1:0] shifted;
      assign fb      = (wide_i ? chain[b][W-1] : chain[b][NW-1]) ^ byte_i[BITS-1-b];
      assign shifted = {chain[b][W-2:0], 1'b0} ^ (fb ? poly_i : '0);
      assign chain[b+1] = wide_i ? shifted : {{(W-NW){1'b0}}, shifted[NW-1:0]};
    end
  endgenerate

  assign state_o = chain[BITS];
endmodule

// File: rtl/crc_in_xform.sv
module crc_in_xform #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] data_i,
  input  logic               mir_i,
  input  logic               inv_i,
  output logic [8*LANES-1:0] data_o
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] raw;
      logic [7:0] mir;
      assign raw = data_i[8*k +: 8];
      for (genvar i = 0; i < 8; i++) begin : g_rev
        assign mir[i] = raw[7-i];
      end
      assign data_o[8*k +: 8] = (mir_i ? mir : raw) ^ {8{inv_i}};
    end
  endgenerate
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic [W-1:0] state_i,
  input  logic         wide_i,
  input  logic         mir_i,
  input  logic         inv_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0]  rev_w;
  logic [NW-1:0] rev_n;
  logic [W-1:0]  sel;
  logic [W-1:0]  mask;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rw
      assign rev_w[i] = state_i[W-1-i];
    end
    for (genvar i = 0; i < NW; i++) begin : g_rn
      assign rev_n[i] = state_i[NW-1-i];
    end
  endgenerate

  assign mask = wide_i ? '1 : {{(W-NW){1'b0}}, {NW{1'b1}}};

  always_comb begin
    if (mir_i) sel = wide_i ? rev_w : {{(W-NW){1'b0}}, rev_n};
    else       sel = state_i & mask;
    sum_o = (sel ^ (inv_i ? mask : '0)) & mask;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data
);
  mode_t             mode_q;
  logic [DATA_W-1:0] state_q;
  logic [DATA_W-1:0] taps;
  logic              wide;
  logic [DATA_W-1:0] din_x;
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] next_data;
  logic [DATA_W-1:0] seed_val;
  logic [LANES:0][DATA_W-1:0] lane_st;

  assign taps = poly_taps(mode_q.poly);
  assign wide = poly_is_wide(mode_q.poly);

  crc_in_xform #(.LANES(LANES)) u_in (
    .data_i (req_wdata),
    .mir_i  (mode_q.mir_in),
    .inv_i  (mode_q.inv_in),
    .data_o (din_x)
  );

  assign lane_st[0] = state_q;
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      crc_byte_step #(.W(DATA_W), .NW(NARROW), .BITS(8)) u_step (
        .state_i (lane_st[k]),
        .byte_i  (din_x[8*k +: 8]),
        .wide_i  (wide),
        .poly_i  (taps),
        .state_o (lane_st[k+1])
      );
    end
  endgenerate

  assign next_data = req_size ? lane_st[LANES] : lane_st[1];
  assign seed_val  = wide ? req_wdata : {{(DATA_W-NARROW){1'b0}}, req_wdata[NARROW-1:0]};

  crc_out_xform #(.W(DATA_W), .NW(NARROW)) u_out (
    .state_i (state_q),
    .wide_i  (wide),
    .mir_i   (mode_q.mir_out),
    .inv_i   (mode_q.inv_out),
    .sum_o   (sum_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      state_q <= RESET_STATE;
    end else if (req_valid && req_write) begin
      case (req_addr)
        ADDR_MODE: mode_q  <= mode_t'(req_wdata[MODE_W-1:0]);
        ADDR_SEED: state_q <= seed_val;
        ADDR_DATA: state_q <= next_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      ADDR_MODE: rd_data = {{(DATA_W-MODE_W){1'b0}}, mode_q};
      ADDR_DATA: rd_data = sum_w;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  import crc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [MODE_W-1:0] mode_q,
  input logic [DATA_W-1:0] state_q,
  input logic [DATA_W-1:0] sum_w
);
  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_q == RESET_STATE && mode_q == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_write) |=> ($stable(state_q) && $stable(mode_q))); // R11

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_SEED && mode_q[1:0] == 2'd2)
      |=> (state_q == $past(req_wdata))); // R3

  AST_MODE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_MODE) |=> $stable(state_q)); // R7

  AST_NARROW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] != 2'd2) |-> (sum_w[DATA_W-1:NARROW] == '0)); // R7

  AST_RAW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b00 && mode_q[1:0] == 2'd2) |-> (sum_w == state_q)); // R8
endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .mode_q    (mode_q),
  .state_q   (state_q),
  .sum_w     (sum_w)
);

// File: tb/sim_crc_engine.sv
`timescale 1ns/1ps
module sim_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_size = 1'b0;
  logic [3:0]  req_addr = 4'h0;
  logic [31:0] req_wdata = 32'h0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [5:0]  m_mode;
  logic [31:0] m_state;

  always #5 clk = ~clk;

  crc_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data)
  );

  function automatic logic [31:0] m_taps(input logic [1:0] p);
    case (p)
      2'd1: return 32'h0000_8005;
      2'd2: return 32'h04C1_1DB7;
      default: return 32'h0000_1021;
    endcase
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] s, input logic [7:0] d,
                                         input logic [1:0] p);
    logic [31:0] t;
    int top;
    t = s;
    top = (p == 2'd2) ? 31 : 15;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = t[top] ^ d[i];
      t = t << 1;
      if (fb) t = t ^ m_taps(p);
      if (p != 2'd2) t = t & 32'h0000_FFFF;
    end
    return t;
  endfunction

  function automatic logic [31:0] m_sum(input logic [31:0] s, input logic [5:0] md);
    logic [31:0] r;
    int w;
    w = (md[1:0] == 2'd2) ? 32 : 16;
    r = 32'h0;
    for (int i = 0; i < w; i++) r[i] = md[4] ? s[w-1-i] : s[i];
    if (md[5]) for (int i = 0; i < w; i++) r[i] = ~r[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic sz, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    case (a)
      4'h0: m_mode = d[5:0];
      4'h4: m_state = (m_mode[1:0] == 2'd2) ? d : {16'h0, d[15:0]};
      4'h8: for (int k = 0; k < (sz ? 4 : 1); k++) begin
              logic [7:0] b;
              b = d[8*k +: 8];
              if (m_mode[2]) b = rev8(b);
              if (m_mode[3]) b = ~b;
              m_state = m_step(m_state, b, m_mode[1:0]);
            end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    req_valid = 1'b0; req_write = 1'b0; req_addr = a;
    #1 v = rd_data;
  endtask

  task automatic check_sum(input string req);
    logic [31:0] v;
    rd(4'h8, v);
    check(req, v, m_sum(m_state, m_mode));
  endtask

  task automatic feed_digits(input bit words);
    if (words) begin
      wr(4'h8, 1'b1, 32'h3433_3231);
      wr(4'h8, 1'b1, 32'h3837_3635);
      wr(4'h8, 1'b0, 32'h0000_0039);
    end else begin
      for (int i = 0; i < 9; i++) wr(4'h8, 1'b0, 32'h31 + i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] saved;
    void'($urandom(32'd20240611));
    m_mode = 6'h0; m_state = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'h0, v); check("R1 mode", v, 32'h0);
    rd(4'h8, v); check("R1 sum", v, 32'h0000_FFFF);

    // R9 check value, byte writes (R4)
    wr(4'h0, 1'b0, 32'h0); wr(4'h4, 1'b0, 32'hFFFF);
    feed_digits(1'b0);
    rd(4'h8, v); check("R9 R4 bytes", v, 32'h0000_29B1);

    // R5 same result with word writes
    wr(4'h4, 1'b0, 32'hFFFF);
    feed_digits(1'b1);
    rd(4'h8, v); check("R5 words", v, 32'h0000_29B1);

    // R7 output flags present only
    wr(4'h0, 1'b0, 32'h20);
    rd(4'h8, v); check("R7 invert", v, 32'h0000_D64E);
    wr(4'h0, 1'b0, 32'h10);
    rd(4'h8, v); check("R7 mirror", v, 32'h0000_8D94);
    wr(4'h0, 1'b0, 32'h0);
    rd(4'h8, v); check("R7 restored", v, 32'h0000_29B1);

    // R10 reflected 32-bit check, words then bytes
    wr(4'h0, 1'b0, 32'h36); wr(4'h4, 1'b0, 32'hFFFF_FFFF);
    feed_digits(1'b1);
    rd(4'h8, v); check("R10 words", v, 32'hCBF4_3926);
    wr(4'h4, 1'b0, 32'hFFFF_FFFF);
    feed_digits(1'b0);
    rd(4'h8, v); check("R10 bytes R6", v, 32'hCBF4_3926);

    // R8 split and resume
    wr(4'h0, 1'b0, 32'h0); wr(4'h4, 1'b0, 32'hFFFF);
    for (int i = 0; i < 5; i++) wr(4'h8, 1'b0, 32'h31 + i);
    rd(4'h8, saved);
    wr(4'h4, 1'b0, 32'h1234);
    wr(4'h8, 1'b1, 32'hDEAD_BEEF);
    wr(4'h4, 1'b0, saved);
    for (int i = 5; i < 9; i++) wr(4'h8, 1'b0, 32'h31 + i);
    rd(4'h8, v); check("R8 resume", v, 32'h0000_29B1);

    // R11 ignored address and idle cycles
    wr(4'hC, 1'b1, 32'hFFFF_FFFF);
    rd(4'h8, v); check("R11 bad addr", v, 32'h0000_29B1);
    req_valid = 1'b0; req_write = 1'b1; req_addr = 4'h8; req_wdata = 32'h5555_AAAA;
    @(negedge clk);
    rd(4'h8, v); check("R11 idle", v, 32'h0000_29B1);

    // R2 mode readback and reserved polynomial
    wr(4'h0, 1'b0, 32'hFFFF_FFC3);
    rd(4'h0, v); check("R2 readback", v, 32'h0000_0003);
    wr(4'h4, 1'b0, 32'hFFFF);
    feed_digits(1'b0);
    rd(4'h8, v); check("R2 reserved", v, 32'h0000_29B1);

    // R3 narrow seed keeps low half
    wr(4'h4, 1'b0, 32'hABCD_1234);
    rd(4'h8, v); check("R3 narrow seed", v, 32'h0000_1234);

    // random mix against the model (R4 R5 R6 R7 R3 R2 R11)
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: begin
             wr(4'h0, 1'b0, $urandom());
             rd(4'h0, v); check("R2 random mode", v, {26'h0, m_mode});
           end
        1: wr(4'h4, 1'b0, $urandom());
        8: begin
             req_valid = 1'b0; req_write = 1'b1; req_addr = 4'h8; req_wdata = $urandom();
             @(negedge clk);
           end
        9: wr(4'hC, 1'($urandom_range(0, 1)), $urandom());
        default: wr(4'h8, 1'($urandom_range(0, 1)), $urandom());
      endcase
      check_sum("R6 R7 random sum");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule